// File: doc/BRIEF.md
# Partitioned Logical and Bit-Count Unit

This execution stage sits in a 64-bit integer pipeline and covers the logical group of operations. Each cycle it takes two operands, an operation code, a size code, a word-mode flag, a leading/trailing select and an opaque context record. One clock later it presents a 64-bit result and the same context. The operations are bitwise AND, OR and XOR, population count split into byte, word or doubleword lanes, lane parity built from the low bit of every byte, and a count of leading or trailing zeros over either the low 32 bits or the full 64 bits of operand A.

The lane counters and the parity trees for each supported lane width run side by side. The opcode and size code pick one of their outputs. Both zero-count directions share one lowest-set-bit search per width: for leading zeros the search is fed the operand with its bits reversed.

Top module: `plbc_unit`

## Requirements
- R1: With opcode 0, 1 or 2 the result is A AND B, A OR B or A XOR B over all 64 bits.
- R2: With opcode 3 and size code 8, the result is the number of set bits in all 64 bits of A.
- R3: With opcode 3 and size code 4, result bits [31:0] hold the set-bit count of A[31:0] and bits [63:32] hold the count of A[63:32].
- R4: With opcode 3 and size code 1, each result byte holds the set-bit count of the matching byte of A.
- R5: With opcode 4 and size code 8, result bit 0 is the XOR of A bits 0, 8, 16, 24, 32, 40, 48 and 56, and all other result bits are zero.
- R6: With opcode 4 and size code 4, result bit 0 is the XOR of A bits 0, 8, 16 and 24, result bit 32 is the XOR of A bits 32, 40, 48 and 56, and all other result bits are zero.
- R7: With opcode 5 and word mode set, only A[31:0] is examined. Select 0 returns the index of the lowest set bit (trailing zeros) and select 1 returns the number of zeros above the highest set bit of that word (leading zeros).
- R8: With opcode 5 and word mode clear, the same trailing (select 0) or leading (select 1) count is taken over all 64 bits of A.
- R9: A zero count whose examined bits are all zero returns 32 in word mode and 64 in full mode.
- R10: The context output equals the context input of the previous cycle.
- R11: Result bits not written by the chosen operation are zero. Opcodes 6 and 7, size codes other than 1, 4 and 8 for opcode 3, and size codes other than 4 and 8 for opcode 4 give an all-zero result.
- R12: The result and context appear one clock after the inputs. While reset is asserted (active low) both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Opcode: 0 AND, 1 OR, 2 XOR, 3 popcount, 4 parity, 5 zero count |
| size_i | input | 4 | Lane size in bytes: 1, 4 or 8 |
| word_mode_i | input | 1 | Zero count on low 32 bits when set |
| lead_sel_i | input | 1 | Zero count direction: 1 leading, 0 trailing |
| a_i | input | DATA_W | Operand A |
| b_i | input | DATA_W | Operand B |
| ctx_i | input | CTX_W | Operation context record |
| result_o | output | DATA_W | Registered result |
| ctx_o | output | CTX_W | Registered context |

## Verification
Every cycle the result computation and the context pass-through happen together, and the opcode, size and lead select may all change from one cycle to the next. The bench issues a new operation with a fresh random context on every clock, so a wrong alignment between the two paths, or leftover state from the previous operation, shows up as a mismatch against the queued item. Each popped item is judged twice, once on the result against a bit-by-bit model and once on the context. All-zero, all-ones, single-bit and high-word-only operands reach the lane and search boundaries.

// File: rtl/plbc_pkg.sv
package plbc_pkg;

    typedef enum logic [2:0] {
        OPC_AND    = 3'd0,
        OPC_OR     = 3'd1,
        OPC_XOR    = 3'd2,
        OPC_POPCNT = 3'd3,
        OPC_PARITY = 3'd4,
        OPC_ZCOUNT = 3'd5
    } plbc_opc_e;

    // size codes are byte counts of one lane
    localparam logic [3:0] SZ_BYTE  = 4'd1;
    localparam logic [3:0] SZ_WORD  = 4'd4;
    localparam logic [3:0] SZ_DWORD = 4'd8;

endpackage

// File: rtl/plbc_lane_popcount.sv
module plbc_lane_popcount #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned LANE_W = 8
) (
    input  logic [DATA_W-1:0] vec_i,
    output logic [DATA_W-1:0] cnt_o
);
    localparam int unsigned LANES = DATA_W / LANE_W;
    localparam int unsigned CW    = $clog2(LANE_W + 1);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [CW-1:0] sum;
        always_comb begin
            sum = '0;
            for (int i = 0; i < LANE_W; i++) begin
                sum = sum + CW'(vec_i[g*LANE_W + i]);
            end
        end
        assign cnt_o[g*LANE_W +: LANE_W] = LANE_W'(sum);
    end

endmodule

// File: rtl/plbc_lane_parity.sv
module plbc_lane_parity #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned LANE_W = 32
) (
    input  logic [DATA_W-1:0] vec_i,
    output logic [DATA_W-1:0] par_o
);
    localparam int unsigned LANES = DATA_W / LANE_W;
    localparam int unsigned BYTES = LANE_W / 8;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic p;
        always_comb begin
            p = 1'b0;
            for (int k = 0; k < BYTES; k++) begin
                p = p ^ vec_i[g*LANE_W + 8*k];
            end
        end
        assign par_o[g*LANE_W +: LANE_W] = {{(LANE_W-1){1'b0}}, p};
    end

endmodule

// File: rtl/plbc_low_set_search.sv
module plbc_low_set_search #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0]               vec_i,
    output logic [$clog2(W+1)-1:0]     idx_o
);
    localparam int unsigned CW = $clog2(W + 1);

    // scan from the top so the last hit is the lowest set bit
    always_comb begin
        idx_o = CW'(W);
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o = CW'(i);
            end
        end
    end

endmodule

// File: rtl/plbc_unit.sv
module plbc_unit
    import plbc_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned CTX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic [3:0]        size_i,
    input  logic              word_mode_i,
    input  logic              lead_sel_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [CTX_W-1:0]  ctx_i,
    output logic [DATA_W-1:0] result_o,
    output logic [CTX_W-1:0]  ctx_o
);
    localparam int unsigned HALF_W  = DATA_W / 2;
    localparam int unsigned CNT_W   = $clog2(DATA_W + 1);
    localparam int unsigned HCNT_W  = $clog2(HALF_W + 1);

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic [CTX_W-1:0]  ctx;
    } stage_t;

    stage_t stage_d, stage_q;

    // lane results, all computed in parallel
    logic [DATA_W-1:0] pc_byte, pc_word, pc_dword;
    logic [DATA_W-1:0] par_word, par_dword;

    plbc_lane_popcount #(.DATA_W(DATA_W), .LANE_W(8)) u_pc_byte (
        .vec_i(a_i), .cnt_o(pc_byte)
    );
    plbc_lane_popcount #(.DATA_W(DATA_W), .LANE_W(HALF_W)) u_pc_word (
        .vec_i(a_i), .cnt_o(pc_word)
    );
    plbc_lane_popcount #(.DATA_W(DATA_W), .LANE_W(DATA_W)) u_pc_dword (
        .vec_i(a_i), .cnt_o(pc_dword)
    );
    plbc_lane_parity #(.DATA_W(DATA_W), .LANE_W(HALF_W)) u_par_word (
        .vec_i(a_i), .par_o(par_word)
    );
    plbc_lane_parity #(.DATA_W(DATA_W), .LANE_W(DATA_W)) u_par_dword (
        .vec_i(a_i), .par_o(par_dword)
    );

    // bit reversal turns a leading-zero count into a lowest-set-bit search
    logic [HALF_W-1:0] low_rev;
    logic [DATA_W-1:0] full_rev;

    for (genvar g = 0; g < HALF_W; g++) begin : g_rev_low
        assign low_rev[g] = a_i[HALF_W-1-g];
    end
    for (genvar g = 0; g < DATA_W; g++) begin : g_rev_full
        assign full_rev[g] = a_i[DATA_W-1-g];
    end

    logic [HALF_W-1:0] zs_word_in;
    logic [DATA_W-1:0] zs_full_in;
    logic [HCNT_W-1:0] zc_word;
    logic [CNT_W-1:0]  zc_full;

    assign zs_word_in = lead_sel_i ? low_rev  : a_i[HALF_W-1:0];
    assign zs_full_in = lead_sel_i ? full_rev : a_i;

    plbc_low_set_search #(.W(HALF_W)) u_zs_word (
        .vec_i(zs_word_in), .idx_o(zc_word)
    );
    plbc_low_set_search #(.W(DATA_W)) u_zs_full (
        .vec_i(zs_full_in), .idx_o(zc_full)
    );

    always_comb begin
        stage_d        = '0;
        stage_d.ctx    = ctx_i;
        unique case (op_i)
            OPC_AND: stage_d.result = a_i & b_i;
            OPC_OR:  stage_d.result = a_i | b_i;
            OPC_XOR: stage_d.result = a_i ^ b_i;
            OPC_POPCNT: begin
                unique case (size_i)
                    SZ_BYTE:  stage_d.result = pc_byte;
                    SZ_WORD:  stage_d.result = pc_word;
                    SZ_DWORD: stage_d.result = pc_dword;
                    default:  stage_d.result = '0;
                endcase
            end
            OPC_PARITY: begin
                unique case (size_i)
                    SZ_WORD:  stage_d.result = par_word;
                    SZ_DWORD: stage_d.result = par_dword;
                    default:  stage_d.result = '0;
                endcase
            end
            OPC_ZCOUNT: begin
                stage_d.result = word_mode_i ? DATA_W'(zc_word) : DATA_W'(zc_full);
            end
            default: stage_d.result = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign result_o = stage_q.result;
    assign ctx_o    = stage_q.ctx;

endmodule

// File: rtl/plbc_checker.sv
module plbc_checker
    import plbc_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned CTX_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        op_i,
    input logic [3:0]        size_i,
    input logic              word_mode_i,
    input logic              lead_sel_i,
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_i,
    input logic [CTX_W-1:0]  ctx_i,
    input logic [DATA_W-1:0] result_o,
    input logic [CTX_W-1:0]  ctx_o
);
    localparam logic [DATA_W-1:0] PAR_MASK =
        DATA_W'(1) | (DATA_W'(1) << (DATA_W / 2));

    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    assert_and_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(op_i) == OPC_AND) |-> (result_o == ($past(a_i) & $past(b_i))));

    assert_full_popcount_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(op_i) == OPC_POPCNT && $past(size_i) == SZ_DWORD)
        |-> (result_o <= DATA_W'(DATA_W)));

    assert_word_count_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(op_i) == OPC_ZCOUNT && $past(word_mode_i))
        |-> (result_o <= DATA_W'(DATA_W / 2)));

    assert_trailing_bit0_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(op_i) == OPC_ZCOUNT && !$past(word_mode_i)
         && !$past(lead_sel_i) && $past(a_i[0])) |-> (result_o == '0));

    assert_ctx_passthrough_R10: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (ctx_o == $past(ctx_i)));

    assert_parity_clean_bits_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(op_i) == OPC_PARITY) |-> ((result_o & ~PAR_MASK) == '0));

endmodule

bind plbc_unit plbc_checker #(.DATA_W(DATA_W), .CTX_W(CTX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .size_i(size_i),
    .word_mode_i(word_mode_i), .lead_sel_i(lead_sel_i), .a_i(a_i), .b_i(b_i),
    .ctx_i(ctx_i), .result_o(result_o), .ctx_o(ctx_o)
);

// File: tb/tb_plbc_unit.sv
module tb_plbc_unit;
    localparam int DW = 64;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    op = '0;
    logic [3:0]    size = '0;
    logic          word_mode = 1'b0;
    logic          lead_sel = 1'b0;
    logic [DW-1:0] a = '0;
    logic [DW-1:0] b = '0;
    logic [CW-1:0] ctx = '0;
    logic [DW-1:0] result;
    logic [CW-1:0] ctx_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [DW-1:0] exp_res_q[$];
    logic [CW-1:0] exp_ctx_q[$];
    string         tag_q[$];

    always #10 clk = ~clk;   // 50 MHz

    plbc_unit #(.DATA_W(DW), .CTX_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .size_i(size),
        .word_mode_i(word_mode), .lead_sel_i(lead_sel), .a_i(a), .b_i(b),
        .ctx_i(ctx), .result_o(result), .ctx_o(ctx_out)
    );

    // bit-by-bit reference built from the requirement text
    function automatic logic [63:0] model(logic [2:0] o, logic [3:0] s, logic wm,
                                          logic ld, logic [63:0] x, logic [63:0] y);
        logic [63:0] r;
        int n;
        int w;
        int idx;
        r = '0;
        case (o)
            3'd0: r = x & y;
            3'd1: r = x | y;
            3'd2: r = x ^ y;
            3'd3: begin
                if (s == 4'd8) begin
                    n = 0;
                    for (int i = 0; i < 64; i++) n += int'(x[i]);
                    r = 64'(n);
                end else if (s == 4'd4) begin
                    for (int h = 0; h < 2; h++) begin
                        n = 0;
                        for (int i = 0; i < 32; i++) n += int'(x[32*h + i]);
                        r[32*h +: 32] = 32'(n);
                    end
                end else if (s == 4'd1) begin
                    for (int h = 0; h < 8; h++) begin
                        n = 0;
                        for (int i = 0; i < 8; i++) n += int'(x[8*h + i]);
                        r[8*h +: 8] = 8'(n);
                    end
                end
            end
            3'd4: begin
                if (s == 4'd8) begin
                    for (int k = 0; k < 8; k++) r[0] = r[0] ^ x[8*k];
                end else if (s == 4'd4) begin
                    for (int k = 0; k < 4; k++) begin
                        r[0]  = r[0]  ^ x[8*k];
                        r[32] = r[32] ^ x[32 + 8*k];
                    end
                end
            end
            3'd5: begin
                w = wm ? 32 : 64;
                n = w;
                for (int i = 0; i < w; i++) begin
                    idx = ld ? (w - 1 - i) : i;
                    if (x[idx] && n == w) n = i;
                end
                r = 64'(n);
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    // driver: one operation per cycle, expected item pushed to the scoreboard
    task automatic issue(input logic [2:0] o, input logic [3:0] s, input logic wm,
                         input logic ld, input logic [63:0] x, input logic [63:0] y,
                         input string tag);
        logic [CW-1:0] c;
        c = CW'($urandom);
        @(negedge clk);
        op = o; size = s; word_mode = wm; lead_sel = ld; a = x; b = y; ctx = c;
        exp_res_q.push_back(model(o, s, wm, ld, x, y));
        exp_ctx_q.push_back(c);
        tag_q.push_back(tag);
    endtask

    // monitor: compare one item per cycle, away from the edge
    always @(posedge clk) begin
        #5;
        if (exp_res_q.size() > 0) begin
            logic [DW-1:0] er;
            logic [CW-1:0] ec;
            string t;
            er = exp_res_q.pop_front();
            ec = exp_ctx_q.pop_front();
            t  = tag_q.pop_front();
            checks++;
            if (result !== er) begin
                errors++;
                $display("FAIL %s result: actual=%h expected=%h", t, result, er);
            end
            checks++;
            if (ctx_out !== ec) begin
                errors++;
                $display("FAIL R10 context (%s): actual=%h expected=%h", t, ctx_out, ec);
            end
        end
    end

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    initial begin
        // R12: outputs held at zero during reset even with live inputs
        a = '1; b = '1; op = 3'd1; ctx = '1;
        repeat (3) @(negedge clk);
        checks++;
        if (result !== '0 || ctx_out !== '0) begin
            errors++;
            $display("FAIL R12 reset: actual=%h/%h expected=0/0", result, ctx_out);
        end
        rst_n = 1'b1;

        // R1: logical operations
        for (int i = 0; i < 6; i++) begin
            issue(3'd0, 4'd8, 1'b0, 1'b0, rnd64(), rnd64(), "R1 and");
            issue(3'd1, 4'd8, 1'b0, 1'b0, rnd64(), rnd64(), "R1 or");
            issue(3'd2, 4'd8, 1'b0, 1'b0, rnd64(), rnd64(), "R1 xor");
        end
        issue(3'd0, 4'd0, 1'b1, 1'b1, '1, '0, "R1 and ones/zero");
        issue(3'd2, 4'd0, 1'b1, 1'b1, '1, '1, "R1 xor ones");

        // R2, R3, R4: popcount lanes
        for (int i = 0; i < 8; i++) begin
            issue(3'd3, 4'd8, 1'b0, 1'b0, rnd64(), rnd64(), "R2 popcount dword");
            issue(3'd3, 4'd4, 1'b0, 1'b0, rnd64(), rnd64(), "R3 popcount word");
            issue(3'd3, 4'd1, 1'b0, 1'b0, rnd64(), rnd64(), "R4 popcount byte");
        end
        issue(3'd3, 4'd8, 1'b0, 1'b0, '1, '0, "R2 popcount ones");
        issue(3'd3, 4'd4, 1'b0, 1'b0, '1, '0, "R3 popcount ones");
        issue(3'd3, 4'd1, 1'b0, 1'b0, '1, '0, "R4 popcount ones");
        issue(3'd3, 4'd4, 1'b0, 1'b0, 64'hFFFF_FFFF_0000_0000, '0, "R3 popcount high half");
        issue(3'd3, 4'd1, 1'b0, 1'b0, '0, '1, "R4 popcount zero");

        // R5, R6: parity from byte low bits
        for (int i = 0; i < 8; i++) begin
            issue(3'd4, 4'd8, 1'b0, 1'b0, rnd64(), '0, "R5 parity dword");
            issue(3'd4, 4'd4, 1'b0, 1'b0, rnd64(), '0, "R6 parity word");
        end
        issue(3'd4, 4'd8, 1'b0, 1'b0, '1, '0, "R5 parity ones");
        issue(3'd4, 4'd4, 1'b0, 1'b0, '1, '0, "R6 parity ones");
        issue(3'd4, 4'd4, 1'b0, 1'b0, 64'h0000_0001_0000_0000, '0, "R6 parity high only");
        issue(3'd4, 4'd8, 1'b0, 1'b0, 64'hFEFE_FEFE_FEFE_FEFE, '0, "R5 parity ignores upper bits");

        // R7, R8: zero counts, sparse operands reach deep indices
        for (int i = 0; i < 6; i++) begin
            for (int m = 0; m < 4; m++) begin
                logic [63:0] v;
                v = rnd64() >> ($urandom % 64);
                v = (i % 2 == 0) ? (v << ($urandom % 64)) : v;
                issue(3'd5, 4'd0, m[1], m[0], v, '0, m[1] ? "R7 zero count word" : "R8 zero count full");
            end
        end
        for (int k = 0; k < 64; k += 9) begin
            issue(3'd5, 4'd0, 1'b0, 1'b0, 64'd1 << k, '0, "R8 trailing single bit");
            issue(3'd5, 4'd0, 1'b0, 1'b1, 64'd1 << k, '0, "R8 leading single bit");
            issue(3'd5, 4'd0, 1'b1, 1'b1, 64'd1 << k, '0, "R7 leading single bit");
        end
        issue(3'd5, 4'd0, 1'b1, 1'b1, 64'hFFFF_FFFF_0000_0001, '0, "R7 leading ignores high word");
        issue(3'd5, 4'd0, 1'b1, 1'b0, 64'h8000_0000_8000_0000, '0, "R7 trailing bit31");

        // R9: all-zero examined bits
        issue(3'd5, 4'd0, 1'b1, 1'b0, '0, '1, "R9 word trailing zero input");
        issue(3'd5, 4'd0, 1'b1, 1'b1, 64'hFFFF_FFFF_0000_0000, '0, "R9 word leading, high word only");
        issue(3'd5, 4'd0, 1'b0, 1'b0, '0, '1, "R9 full trailing zero input");
        issue(3'd5, 4'd0, 1'b0, 1'b1, '0, '1, "R9 full leading zero input");

        // R11: unused opcodes and sizes give zero
        issue(3'd6, 4'd8, 1'b0, 1'b0, '1, '1, "R11 opcode 6");
        issue(3'd7, 4'd4, 1'b1, 1'b1, '1, '1, "R11 opcode 7");
        issue(3'd3, 4'd2, 1'b0, 1'b0, '1, '1, "R11 popcount size 2");
        issue(3'd4, 4'd1, 1'b0, 1'b0, '1, '1, "R11 parity size 1");
        issue(3'd4, 4'd0, 1'b0, 1'b0, '1, '1, "R11 parity size 0");

        // R12: idle cycles drain the queue, one-cycle latency verified above
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R12 watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule